// File: doc/BRIEF.md
# Key Share Store with Prioritised Update Source

This block keeps the working key material of a key-derivation pipeline: two derivation slots, each made of two shares, each share built from four words. On every clock edge where updates are enabled it picks exactly one source for the next contents and writes it. The sources are a wipe with fresh entropy, a random fill, a load of the root key, and the result of a hash operation. A fixed priority chain between these sources decides the outcome when several requests are raised at once.

The result of an acknowledged operation is not always written. Depending on the error class reported with it, the store loads the hash output, wipes itself, or keeps its contents. The block also presents one slot as a read view for the hash engine. When the stage is marked unusable, that view is replaced by entropy. A data-enable flag tells the downstream engine when the data it receives is not real key material.

The hash engine, the entropy source and the sequencing state machine sit outside this block. They drive its request and status inputs.

Top module: `key_store_upd`

## Requirements
- R1: While reset is asserted, and after it is released, every bit of `key_o` is zero until the first enabled update. Slot c, share s occupies `key_o[(c*2+s)*128 +: 128]`. Word w of a share occupies bits `[w*32 +: 32]` of that share.
- R2: When `upd_en_i` is low, `key_o` keeps its value across the clock edge, whatever requests are present.
- R3: A wipe request has the highest priority. Word w of share s in slot c becomes entropy word s (`entropy_i[s*32 +: 32]`) rotated left by c*4+w bits.
- R4: A random-fill request, when no wipe is pending, writes every word of share s in both slots with entropy word s.
- R5: With no wipe or random request, `init_i` selects a root load. When both bits of `root_vld_i` are set, the root shares (share s at `root_key_i[s*128 +: 128]`) are written into both slots. Otherwise the store is unchanged. The root load takes precedence over any operation result.
- R6: With none of the above pending, an operation result is used only when `op_ack_i` or `op_upd_i` is high. The rules are applied in this order: an invalid state loads the hash result; otherwise a fault error wipes (as in R3); otherwise a disabled state loads the hash result; otherwise an operation error keeps the contents; otherwise the hash result is loaded. With neither ack nor update, the store is unchanged.
- R7: A hash load writes `hash_data_i` (share s at bits `[s*128 +: 128]`) into the slot named by `slot_sel_i`, and only when `op_code_i` is 2'b00 (advance) or 2'b11 (disable). The codes 2'b01 and 2'b10 leave that slot unchanged. The other slot is never touched by a hash load.
- R8: When `stage_bad_i` is high, share s of `view_o` is entropy word s repeated in all four words. Otherwise `view_o` equals the stored slot named by `slot_sel_i`. The view follows its inputs in the same cycle.
- R9: `data_en_o` is high exactly when any of `rand_req_i`, `st_disabled_i`, `st_invalid_i` or `wipe_req_i` is high, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Allows the store to change on this edge |
| wipe_req_i | input | 1 | Request to overwrite everything with entropy |
| rand_req_i | input | 1 | Request to fill with replicated entropy |
| init_i | input | 1 | Initialisation phase, selects root load |
| root_key_i | input | 256 | Root key, two shares of 128 bits |
| root_vld_i | input | 2 | Validity of each root share |
| entropy_i | input | 64 | One 32-bit entropy word per share |
| hash_data_i | input | 256 | Hash engine result, two shares |
| op_code_i | input | 2 | Operation: 00 advance, 01 id, 10 output, 11 disable |
| op_ack_i | input | 1 | Operation acknowledged |
| op_upd_i | input | 1 | Operation update strobe |
| st_invalid_i | input | 1 | Sequencer is in its invalid state |
| fault_err_i | input | 1 | Fault-class error |
| st_disabled_i | input | 1 | Sequencer is in its disabled state |
| op_err_i | input | 1 | Operation-class error |
| slot_sel_i | input | 1 | Slot used for hash loads and the view |
| stage_bad_i | input | 1 | Replace the view with entropy |
| key_o | output | 512 | Whole store, both slots and shares |
| view_o | output | 256 | Selected slot, or entropy |
| data_en_o | output | 1 | Downstream data-enable flag |

## Verification
Every store update is registered. A stimulus applied before a rising edge therefore shows on `key_o` right after that edge. The bench drives on the falling edge and compares `key_o` on the next falling edge, one full cycle later. `view_o` and `data_en_o` are combinational, so they are compared one nanosecond after their inputs change, with no clock edge in between. The expected store contents come from a model in the bench that applies each requirement's source rule to the previous expected value.

// File: rtl/kst_pkg.sv
package kst_pkg;
    parameter int unsigned WORD_W = 32;
    parameter int unsigned WORDS  = 4;
    parameter int unsigned SHARES = 2;
    parameter int unsigned SLOTS  = 2;

    localparam int unsigned KEY_W      = WORD_W * WORDS;
    localparam int unsigned SLOT_IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned STORE_W    = SLOTS * SHARES * KEY_W;
    localparam int unsigned VIEW_W     = SHARES * KEY_W;
    localparam int unsigned ENT_W      = SHARES * WORD_W;

    localparam logic [1:0] OP_ADV     = 2'b00;
    localparam logic [1:0] OP_GEN_ID  = 2'b01;
    localparam logic [1:0] OP_GEN_OUT = 2'b10;
    localparam logic [1:0] OP_DIS     = 2'b11;

    typedef logic [WORD_W-1:0]           word_t;
    typedef logic [KEY_W-1:0]            key_t;
    typedef key_t [SHARES-1:0]           shares_t;
    typedef shares_t [SLOTS-1:0]         store_t;
    typedef word_t [SHARES-1:0]          ent_t;

    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_WIPE = 3'd1,
        SRC_RAND = 3'd2,
        SRC_ROOT = 3'd3,
        SRC_HASH = 3'd4
    } upd_src_e;

    typedef struct packed {
        store_t key;
    } kst_state_t;

    function automatic word_t rotl(word_t x, int unsigned n);
        int unsigned m;
        m = n % WORD_W;
        if (m == 0) return x;
        return (x << m) | (x >> (WORD_W - m));
    endfunction
endpackage

// File: rtl/kst_sel.sv
module kst_sel
    import kst_pkg::*;
(
    input  logic     wipe_req_i,
    input  logic     rand_req_i,
    input  logic     init_i,
    input  logic     op_ack_i,
    input  logic     op_upd_i,
    input  logic     st_invalid_i,
    input  logic     fault_err_i,
    input  logic     st_disabled_i,
    input  logic     op_err_i,
    output upd_src_e src_o
);
    upd_src_e op_src;

    // Source picked from an operation outcome, by error class.
    always_comb begin
        op_src = SRC_HOLD;
        if (op_ack_i || op_upd_i) begin
            if (st_invalid_i)       op_src = SRC_HASH;
            else if (fault_err_i)   op_src = SRC_WIPE;
            else if (st_disabled_i) op_src = SRC_HASH;
            else if (op_err_i)      op_src = SRC_HOLD;
            else                    op_src = SRC_HASH;
        end
    end

    // Fixed priority: wipe, random, root, operation.
    always_comb begin
        if (wipe_req_i)      src_o = SRC_WIPE;
        else if (rand_req_i) src_o = SRC_RAND;
        else if (init_i)     src_o = SRC_ROOT;
        else                 src_o = op_src;
    end
endmodule

// File: rtl/kst_next.sv
module kst_next
    import kst_pkg::*;
(
    input  store_t                 cur_i,
    input  upd_src_e               src_i,
    input  ent_t                   ent_i,
    input  shares_t                root_i,
    input  logic [SHARES-1:0]      root_vld_i,
    input  shares_t                hash_i,
    input  logic                   op_load_i,
    input  logic [SLOT_IDX_W-1:0]  slot_sel_i,
    output store_t                 nxt_o
);
    store_t wipe_val;
    store_t rand_val;

    for (genvar c = 0; c < SLOTS; c++) begin : g_slot
        for (genvar s = 0; s < SHARES; s++) begin : g_share
            for (genvar w = 0; w < WORDS; w++) begin : g_word
                assign wipe_val[c][s][w*WORD_W +: WORD_W] = rotl(ent_i[s], c*WORDS + w);
                assign rand_val[c][s][w*WORD_W +: WORD_W] = ent_i[s];
            end
        end
    end

    logic slot_ok;
    assign slot_ok = {1'b0, slot_sel_i} < (SLOT_IDX_W+1)'(SLOTS);

    always_comb begin
        nxt_o = cur_i;
        unique case (src_i)
            SRC_WIPE: nxt_o = wipe_val;
            SRC_RAND: nxt_o = rand_val;
            SRC_ROOT: begin
                if (&root_vld_i) begin
                    for (int c = 0; c < SLOTS; c++) nxt_o[c] = root_i;
                end
            end
            SRC_HASH: begin
                if (op_load_i && slot_ok) nxt_o[slot_sel_i] = hash_i;
            end
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/key_store_upd.sv
module key_store_upd
    import kst_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   upd_en_i,
    input  logic                   wipe_req_i,
    input  logic                   rand_req_i,
    input  logic                   init_i,
    input  logic [VIEW_W-1:0]      root_key_i,
    input  logic [SHARES-1:0]      root_vld_i,
    input  logic [ENT_W-1:0]       entropy_i,
    input  logic [VIEW_W-1:0]      hash_data_i,
    input  logic [1:0]             op_code_i,
    input  logic                   op_ack_i,
    input  logic                   op_upd_i,
    input  logic                   st_invalid_i,
    input  logic                   fault_err_i,
    input  logic                   st_disabled_i,
    input  logic                   op_err_i,
    input  logic [SLOT_IDX_W-1:0]  slot_sel_i,
    input  logic                   stage_bad_i,
    output logic [STORE_W-1:0]     key_o,
    output logic [VIEW_W-1:0]      view_o,
    output logic                   data_en_o
);
    kst_state_t state_d, state_q;
    upd_src_e   src;
    store_t     nxt;
    shares_t    root_s, hash_s, view_s;
    ent_t       ent_s;
    logic       op_load;

    assign root_s  = root_key_i;
    assign hash_s  = hash_data_i;
    assign ent_s   = entropy_i;
    assign op_load = (op_code_i == OP_ADV) || (op_code_i == OP_DIS);

    kst_sel u_sel (
        .wipe_req_i    (wipe_req_i),
        .rand_req_i    (rand_req_i),
        .init_i        (init_i),
        .op_ack_i      (op_ack_i),
        .op_upd_i      (op_upd_i),
        .st_invalid_i  (st_invalid_i),
        .fault_err_i   (fault_err_i),
        .st_disabled_i (st_disabled_i),
        .op_err_i      (op_err_i),
        .src_o         (src)
    );

    kst_next u_next (
        .cur_i      (state_q.key),
        .src_i      (src),
        .ent_i      (ent_s),
        .root_i     (root_s),
        .root_vld_i (root_vld_i),
        .hash_i     (hash_s),
        .op_load_i  (op_load),
        .slot_sel_i (slot_sel_i),
        .nxt_o      (nxt)
    );

    always_comb begin
        state_d = state_q;
        if (upd_en_i) state_d.key = nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    // Read view: entropy replicated per share, or the selected slot.
    always_comb begin
        view_s = state_q.key[0];
        if (stage_bad_i) begin
            for (int s = 0; s < SHARES; s++) view_s[s] = {WORDS{ent_s[s]}};
        end else begin
            for (int c = 0; c < SLOTS; c++) begin
                if (slot_sel_i == SLOT_IDX_W'(c)) view_s = state_q.key[c];
            end
        end
    end

    assign key_o     = state_q.key;
    assign view_o    = view_s;
    assign data_en_o = rand_req_i | st_disabled_i | st_invalid_i | wipe_req_i;
endmodule

// File: rtl/kst_chk.sv
module kst_chk
    import kst_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 upd_en_i,
    input logic                 wipe_req_i,
    input logic                 rand_req_i,
    input logic                 init_i,
    input logic [SHARES-1:0]    root_vld_i,
    input logic [ENT_W-1:0]     entropy_i,
    input logic                 op_ack_i,
    input logic                 op_upd_i,
    input logic                 st_invalid_i,
    input logic                 fault_err_i,
    input logic                 st_disabled_i,
    input logic                 op_err_i,
    input logic [STORE_W-1:0]   key_o,
    input logic                 data_en_o
);
    logic above_op;
    assign above_op = wipe_req_i | rand_req_i | init_i;

    // R1
    always @(posedge clk_i) begin
        if (rst_ni === 1'b0) begin
            reset_clear_chk: assert (key_o == '0);
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_en_i |=> $stable(key_o));

    // R4
    rand_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !wipe_req_i && rand_req_i) |=>
        (key_o[WORD_W-1:0] == $past(entropy_i[WORD_W-1:0]) &&
         key_o[STORE_W-1 -: WORD_W] == $past(entropy_i[ENT_W-1 -: WORD_W])));

    // R5
    root_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !wipe_req_i && !rand_req_i && init_i && !(&root_vld_i)) |=> $stable(key_o));

    // R6
    op_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !above_op && (op_ack_i || op_upd_i) && !st_invalid_i &&
         !fault_err_i && !st_disabled_i && op_err_i) |=> $stable(key_o));

    // R6
    no_ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !above_op && !op_ack_i && !op_upd_i) |=> $stable(key_o));

    // R9
    wipe_data_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wipe_req_i |-> data_en_o);
endmodule

bind key_store_upd kst_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .upd_en_i      (upd_en_i),
    .wipe_req_i    (wipe_req_i),
    .rand_req_i    (rand_req_i),
    .init_i        (init_i),
    .root_vld_i    (root_vld_i),
    .entropy_i     (entropy_i),
    .op_ack_i      (op_ack_i),
    .op_upd_i      (op_upd_i),
    .st_invalid_i  (st_invalid_i),
    .fault_err_i   (fault_err_i),
    .st_disabled_i (st_disabled_i),
    .op_err_i      (op_err_i),
    .key_o         (key_o),
    .data_en_o     (data_en_o)
);

// File: tb/tb_key_store_upd.sv
`timescale 1ns/1ps
module tb_key_store_upd;
    import kst_pkg::*;

    logic                  clk_i = 1'b0;
    logic                  rst_ni = 1'b0;
    logic                  upd_en_i = 1'b0;
    logic                  wipe_req_i = 1'b0, rand_req_i = 1'b0, init_i = 1'b0;
    logic [VIEW_W-1:0]     root_key_i = '0;
    logic [SHARES-1:0]     root_vld_i = '0;
    logic [ENT_W-1:0]      entropy_i = '0;
    logic [VIEW_W-1:0]     hash_data_i = '0;
    logic [1:0]            op_code_i = 2'b00;
    logic                  op_ack_i = 1'b0, op_upd_i = 1'b0;
    logic                  st_invalid_i = 1'b0, fault_err_i = 1'b0;
    logic                  st_disabled_i = 1'b0, op_err_i = 1'b0;
    logic [SLOT_IDX_W-1:0] slot_sel_i = '0;
    logic                  stage_bad_i = 1'b0;
    logic [STORE_W-1:0]    key_o;
    logic [VIEW_W-1:0]     view_o;
    logic                  data_en_o;

    key_store_upd dut (.*);

    always #2.5 clk_i = ~clk_i;

    int tests = 0;
    int fails = 0;
    logic [STORE_W-1:0] exp_key = '0;
    bit finished = 1'b0;

    task automatic check(string tag, logic [STORE_W-1:0] got, logic [STORE_W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rol(logic [31:0] x, int n);
        int m = n % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    function automatic logic [VIEW_W-1:0] rnd_wide();
        logic [VIEW_W-1:0] v;
        for (int k = 0; k < VIEW_W/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Fields: req[19:16] src[15:13] wipe rand init rvld[9:8] ack upd inv fault dis err op[1:0]
    // src: 0 keep, 1 wipe, 2 random, 3 root, 4 hash
    localparam int NV = 17;
    localparam logic [19:0] VECS [NV] = '{
        {4'd5,3'd3,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R5 root load
        {4'd6,3'd4,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R6 clean ack
        {4'd7,3'd4,1'b0,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b11}, // R7 disable op
        {4'd6,3'd0,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00}, // R6 op error keeps
        {4'd6,3'd1,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00}, // R6 fault wipes
        {4'd6,3'd4,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00}, // R6 invalid beats fault
        {4'd6,3'd4,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'b11}, // R6 disabled beats error
        {4'd6,3'd1,1'b0,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00}, // R6 fault beats disabled
        {4'd6,3'd0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00}, // R6 no ack keeps
        {4'd7,3'd4,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01}, // R7 id op keeps
        {4'd5,3'd3,1'b0,1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R5 one share invalid
        {4'd5,3'd3,1'b0,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00}, // R5 root beats op
        {4'd4,3'd2,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R4 random beats root
        {4'd3,3'd1,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R3 wipe beats all
        {4'd4,3'd2,1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R4 random alone
        {4'd3,3'd1,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R3 wipe alone
        {4'd7,3'd4,1'b0,1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10}  // R7 output op keeps
    };

    task automatic model(int src, int sl);
        case (src)
            1: for (int c = 0; c < 2; c++)
                   for (int s = 0; s < 2; s++)
                       for (int w = 0; w < 4; w++)
                           exp_key[(c*2+s)*128 + w*32 +: 32] = rol(entropy_i[s*32 +: 32], c*4+w);
            2: for (int c = 0; c < 2; c++)
                   for (int s = 0; s < 2; s++)
                       exp_key[(c*2+s)*128 +: 128] = {4{entropy_i[s*32 +: 32]}};
            3: if (root_vld_i == 2'b11)
                   for (int c = 0; c < 2; c++) exp_key[c*256 +: 256] = root_key_i;
            4: if (op_code_i == 2'b00 || op_code_i == 2'b11)
                   exp_key[sl*256 +: 256] = hash_data_i;
            default: ;
        endcase
    endtask

    task automatic clear_inputs();
        wipe_req_i = 0; rand_req_i = 0; init_i = 0; root_vld_i = 0;
        op_ack_i = 0; op_upd_i = 0; st_invalid_i = 0; fault_err_i = 0;
        st_disabled_i = 0; op_err_i = 0; op_code_i = 0; stage_bad_i = 0;
    endtask

    initial begin : watchdog
        #1000000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk_i);
        check("R1 in reset", key_o, '0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 after release", key_o, '0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v = VECS[i];
            @(negedge clk_i);
            upd_en_i = 1'b1;
            wipe_req_i = v[12]; rand_req_i = v[11]; init_i = v[10]; root_vld_i = v[9:8];
            op_ack_i = v[7]; op_upd_i = v[6]; st_invalid_i = v[5]; fault_err_i = v[4];
            st_disabled_i = v[3]; op_err_i = v[2]; op_code_i = v[1:0];
            slot_sel_i = SLOT_IDX_W'(i % 2);
            entropy_i = {$urandom, $urandom};
            root_key_i = rnd_wide();
            hash_data_i = rnd_wide();
            #1;
            // R9 data enable
            check("R9 data_en", STORE_W'(data_en_o),
                  STORE_W'(v[11] | v[3] | v[5] | v[12]));
            model(int'(v[15:13]), i % 2);
            @(negedge clk_i);
            check($sformatf("R%0d vector %0d", v[19:16], i), key_o, exp_key);
            clear_inputs();
            upd_en_i = 1'b0;
        end

        // R2: disabled update ignores a wipe and an acked op
        @(negedge clk_i);
        upd_en_i = 1'b0; wipe_req_i = 1'b1; op_ack_i = 1'b1; entropy_i = {$urandom, $urandom};
        hash_data_i = rnd_wide();
        repeat (2) @(negedge clk_i);
        check("R2 update disabled", key_o, exp_key);
        clear_inputs();

        // Put distinct contents in the two slots
        upd_en_i = 1'b1; op_ack_i = 1'b1; op_code_i = 2'b00; slot_sel_i = 0;
        hash_data_i = rnd_wide(); model(4, 0);
        @(negedge clk_i);
        slot_sel_i = 1; hash_data_i = rnd_wide(); model(4, 1);
        @(negedge clk_i);
        clear_inputs(); upd_en_i = 1'b0;
        check("R7 two slots loaded", key_o, exp_key);

        // R8 view
        slot_sel_i = 0; #1;
        check("R8 view slot0", STORE_W'(view_o), STORE_W'(exp_key[0 +: 256]));
        slot_sel_i = 1; #1;
        check("R8 view slot1", STORE_W'(view_o), STORE_W'(exp_key[256 +: 256]));
        stage_bad_i = 1'b1; entropy_i = {32'hC3C3_1234, 32'h5A5A_9876}; #1;
        check("R8 view entropy", STORE_W'(view_o),
              STORE_W'({{4{32'hC3C3_1234}}, {4{32'h5A5A_9876}}}));
        stage_bad_i = 1'b0;

        // R1 reset again clears everything
        @(negedge clk_i);
        rst_ni = 1'b0; #1;
        check("R1 re-reset", key_o, '0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule